// File: doc/BRIEF.md
# Gated Multi-Mode Timer/Counter

This block is one timer/counter channel held in two 8-bit count bytes, a low byte and a high byte. A 2-bit mode field picks how the bytes count: as a 13-bit counter (the whole high byte above the five least significant bits of the low byte), as one 16-bit counter, or as an 8-bit counter in the low byte that refills itself from the high byte. A fourth mode code freezes the count. Each increment comes from one of two sources. The first is an internal tick that fires once every six clocks. The second is a falling edge on an external count pin.

Counting is permitted by a run bit. An optional gate lets an external level pin hold the count, so that software can measure how long that pin stays high. When the active count wraps from all ones to zero, a sticky overflow flag is raised. A software clear pulse or an interrupt-acknowledge pulse lowers it. Software reaches the count bytes, the control field and the flag through a plain single-cycle write port and a combinational read port. These are control paths and carry no handshake.

Top module: `gated_timer`

## Requirements
- R1: Mode code 0 counts the 13-bit value formed by the high byte (upper part) and low byte bits 4..0 (lower part). Low byte bits 7..5 keep their last written value and take no part in the count or its wrap. When the 13-bit value wraps from 0x1FFF to 0, the flag is set.
- R2: An increment is allowed only when the run bit is 1 and either the gate-enable bit is 0 or `gate_pin` is 1. Otherwise both count bytes hold.
- R3: Mode code 1 counts the high and low bytes as one 16-bit up-counter, with the high byte most significant. A wrap from 0xFFFF to 0 sets the flag.
- R4: Mode code 2 counts the low byte only. When an increment finds the low byte at 0xFF, the low byte is loaded with the high byte and the flag is set. The high byte is never changed by counting in this mode.
- R5: `ovf_flag` rises on the clock edge after a wrap and stays high until `flag_clr` or `irq_ack` is sampled high. A wrap in the same cycle as a clear leaves the flag high.
- R6: Source bit 0 counts internal ticks. A tick is a free-running one-cycle pulse every 6 clocks and runs whether or not counting is allowed. Source bit 1 counts falling edges of `cnt_pin`. Each edge passes through a 2-flop synchroniser and is detected by comparing the synchronised level at successive ticks, giving one increment per edge.
- R7: A write to the low or high byte in a cycle cancels that cycle's increment, and any wrap it would have caused. The written byte takes the written value, and the other byte holds.
- R8: Mode code 3 never changes either count byte except by a write.
- R9: Writing the control field, including setting the run bit, never changes the count bytes.
- R10: Address codes are the same for `wr_sel` and `rd_sel`: 0 low byte, 1 high byte, 2 control, 3 flag (read only; the value is in bit 0). Control bits are: bit 0 run, bit 1 gate-enable, bit 2 source, bits 4..3 mode. Control bits 7..5 are not stored and read as 0. After reset, all stored fields and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Write address (0 low, 1 high, 2 control) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read address (0 low, 1 high, 2 control, 3 flag) |
| rd_data | output | 8 | Combinational read data |
| cnt_pin | input | 1 | External count pin, asynchronous |
| gate_pin | input | 1 | External gate level, synchronous to clk |
| flag_clr | input | 1 | Software flag clear pulse |
| irq_ack | input | 1 | Interrupt acknowledge pulse, also clears the flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The properties take for granted that `gate_pin`, `flag_clr`, `irq_ack` and the write port are already synchronous to `clk`. Only `cnt_pin` is re-timed inside the block. The stimulus changes every input only at the falling clock edge, so each is steady around the rising edge. `cnt_pin` is moved either in long steady phases or randomly, and the latter is tolerated because it passes through the synchroniser. The bench keeps `wr_sel` at 0, 1 or 2 whenever `wr_en` is high. It never writes the flag address, which the properties treat as a read-only location.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_HOLD   = 2'd3
  } tmr_mode_e;

  // Packed so that bit 0 is run and bits 4..3 are the mode.
  typedef struct packed {
    tmr_mode_e mode;
    logic      src_ext;
    logic      gate_en;
    logic      run;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);

  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam logic [1:0] SEL_FLAG = 2'd3;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  // Free running: never gated by the timer enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + PW'(1);
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
module tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  // The level is latched only on tick boundaries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_q <= 1'b0;
    else if (tick) seen_q <= sync_q[STAGES-1];
  end

  assign fall = tick && seen_q && !sync_q[STAGES-1];
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int LOW13 = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  tmr_mode_e    mode,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         wrap
);
  localparam int NW = W + LOW13;
  localparam int DW = 2 * W;

  logic          step;
  logic [NW:0]   sum_n;
  logic [DW:0]   sum_d;
  logic [W-1:0]  lo_n, hi_n;

  assign step = inc && !wr_lo && !wr_hi;

  assign sum_n = {1'b0, hi, lo[LOW13-1:0]} + (NW+1)'(1);
  assign sum_d = {1'b0, hi, lo} + (DW+1)'(1);

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    wrap = 1'b0;
    if (step) begin
      case (mode)
        MODE_13: begin
          hi_n             = sum_n[NW-1:LOW13];
          lo_n[LOW13-1:0]  = sum_n[LOW13-1:0];
          wrap             = sum_n[NW];
        end
        MODE_16: begin
          hi_n = sum_d[DW-1:W];
          lo_n = sum_d[W-1:0];
          wrap = sum_d[DW];
        end
        MODE_RELOAD: begin
          if (&lo) begin
            lo_n = hi;
            wrap = 1'b1;
          end else begin
            lo_n = lo + W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wr_data : lo_n;
      hi <= wr_hi ? wr_data : hi_n;
    end
  end
endmodule

// File: rtl/gated_timer.sv
`timescale 1ns/1ps
module gated_timer
  import tmr_pkg::*;
#(
  parameter int W      = 8,
  parameter int LOW13  = 5,
  parameter int DIV    = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         cnt_pin,
  input  logic         gate_pin,
  input  logic         flag_clr,
  input  logic         irq_ack,
  output logic         ovf_flag
);
  tmr_ctl_t     ctl_q;
  logic         tick, fall, cnt_en, wrap;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         wr_lo, wr_hi, wr_ctl;

  assign wr_lo  = wr_en && (wr_sel == SEL_LO);
  assign wr_hi  = wr_en && (wr_sel == SEL_HI);
  assign wr_ctl = wr_en && (wr_sel == SEL_CTL);

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  tmr_edge #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin), .fall(fall)
  );

  assign cnt_en = ctl_q.run
               && (!ctl_q.gate_en || gate_pin)
               && (ctl_q.src_ext ? fall : tick)
               && (ctl_q.mode != MODE_HOLD);

  tmr_count #(.W(W), .LOW13(LOW13)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_en), .mode(ctl_q.mode),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .lo(cnt_lo), .hi(cnt_hi), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= tmr_ctl_t'(wr_data[CTL_W-1:0]);
  end

  // A wrap in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= wrap || (ovf_flag && !(flag_clr || irq_ack));
  end

  always_comb begin
    case (rd_sel)
      SEL_LO:  rd_data = cnt_lo;
      SEL_HI:  rd_data = cnt_hi;
      SEL_CTL: rd_data = W'(ctl_q);
      default: rd_data = W'(ovf_flag);
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] lo,
  input logic [W-1:0] hi,
  input logic [1:0]   mode,
  input logic         run,
  input logic         gate_en,
  input logic         gate_pin,
  input logic         tick,
  input logic         wrap,
  input logic         flag,
  input logic         flag_clr,
  input logic         irq_ack
);
  logic wr_cnt;
  assign wr_cnt = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr && !irq_ack |=> flag); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R5
  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || (gate_en && !gate_pin)) && !wr_cnt |=> $stable(lo) && $stable(hi)); // R2
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 && !wr_cnt |=> $stable(lo) && $stable(hi)); // R8
  AST_RELOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 && !(wr_en && wr_sel == 2'd1) |=> $stable(hi)); // R4
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd0 |=> lo == $past(wr_data)); // R7
  AST_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 && !(wr_en && wr_sel == 2'd0) |=> lo[W-1:5] == $past(lo[W-1:5])); // R1
  AST_WRAP16_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && mode == 2'd1 |=> lo == '0 && hi == '0); // R3
  AST_CTL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 && !run |=> $stable(lo) && $stable(hi)); // R9
endmodule

bind gated_timer tmr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .lo(cnt_lo), .hi(cnt_hi), .mode(ctl_q.mode), .run(ctl_q.run),
  .gate_en(ctl_q.gate_en), .gate_pin(gate_pin), .tick(tick), .wrap(wrap),
  .flag(ovf_flag), .flag_clr(flag_clr), .irq_ack(irq_ack)
);

// File: tb/sim_gated_timer.sv
`timescale 1ns/1ps
module sim_gated_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       cnt_pin = 1'b0;
  logic       gate_pin = 1'b0;
  logic       flag_clr = 1'b0;
  logic       irq_ack = 1'b0;
  logic       ovf_flag;

  always #2.5 clk = ~clk;

  gated_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .ovf_flag(ovf_flag)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference
  int m_phase = 0;
  int m_s1 = 0, m_s2 = 0, m_seen = 0;
  int m_lo = 0, m_hi = 0, m_ctl = 0, m_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_s1 = 0; m_s2 = 0; m_seen = 0;
      m_lo = 0; m_hi = 0; m_ctl = 0; m_flag = 0;
    end else begin
      int run, gate, src, mode, tk, ev, en, wcnt, wrapped, v;
      run  = m_ctl & 1;
      gate = (m_ctl >> 1) & 1;
      src  = (m_ctl >> 2) & 1;
      mode = (m_ctl >> 3) & 3;
      tk = (m_phase == 5) ? 1 : 0;
      m_phase = (m_phase + 1) % 6;
      ev = (tk && m_seen && !m_s2) ? 1 : 0;
      if (tk) m_seen = m_s2;
      m_s2 = m_s1;
      m_s1 = int'(cnt_pin);
      en = (run && (!gate || gate_pin) && (src ? ev : tk) && mode != 3) ? 1 : 0;
      wcnt = (wr_en && wr_sel <= 2'd1) ? 1 : 0;
      wrapped = 0;
      if (en && !wcnt) begin
        if (mode == 0) begin
          v = m_hi * 32 + (m_lo % 32) + 1;
          if (v == 8192) begin v = 0; wrapped = 1; end
          m_hi = v / 32;
          m_lo = (m_lo / 32) * 32 + (v % 32);
        end else if (mode == 1) begin
          v = m_hi * 256 + m_lo + 1;
          if (v == 65536) begin v = 0; wrapped = 1; end
          m_hi = v / 256;
          m_lo = v % 256;
        end else begin
          if (m_lo == 255) begin m_lo = m_hi; wrapped = 1; end
          else m_lo = m_lo + 1;
        end
      end
      if (wr_en) begin
        if (wr_sel == 2'd0) m_lo = int'(wr_data);
        if (wr_sel == 2'd1) m_hi = int'(wr_data);
        if (wr_sel == 2'd2) m_ctl = int'(wr_data) % 32;
      end
      m_flag = (wrapped || (m_flag && !(flag_clr || irq_ack))) ? 1 : 0;
    end
  end

  // Per-clock comparison, away from the rising edge
  int snap_lo = 0, snap_hi = 0, snap_ctl = 0, snap_fl = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string ctag;
      case ((m_ctl >> 3) & 3)
        0: ctag = "R1";
        1: ctag = "R3";
        2: ctag = "R4";
        default: ctag = "R8";
      endcase
      rd_sel = 2'd0; #0.4; snap_lo  = int'(rd_data);
      rd_sel = 2'd1; #0.4; snap_hi  = int'(rd_data);
      rd_sel = 2'd2; #0.4; snap_ctl = int'(rd_data);
      rd_sel = 2'd3; #0.4; snap_fl  = int'(rd_data);
      chk({ctag, " low byte"}, snap_lo, m_lo);
      chk({ctag, " high byte"}, snap_hi, m_hi);
      chk("R10 control readback", snap_ctl, m_ctl);
      chk("R5 flag read", snap_fl, m_flag);
      chk("R5 flag pin", int'(ovf_flag), m_flag);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #2;
      if (snap_fl == 1) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R10 reset low", snap_lo, 0);
    chk("R10 reset high", snap_hi, 0);
    chk("R10 reset control", snap_ctl, 0);
    chk("R10 reset flag", int'(ovf_flag), 0);

    // R9: setting run keeps the count bytes
    wr(2'd2, 8'h08);            // mode 16, stopped
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    idle(20); #2;
    chk("R2 stopped low", snap_lo, 8'h34);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h09;
    @(negedge clk); wr_en = 1'b0; #2;
    chk("R9 run keeps low", snap_lo, 8'h34);
    chk("R9 run keeps high", snap_hi, 8'h12);

    // R3: 16-bit wrap
    wr(2'd2, 8'h08);
    wr(2'd0, 8'hFA);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h09);
    wait_flag();
    chk("R3 wrap low", snap_lo, 0);
    chk("R3 wrap high", snap_hi, 0);
    chk("R5 flag raised", snap_fl, 1);
    idle(10); #2;
    chk("R5 flag sticky", snap_fl, 1);
    pulse_clr(); #2;
    chk("R5 flag cleared", snap_fl, 0);

    // R1: 13-bit wrap, upper low bits untouched
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFE);
    wr(2'd2, 8'h01);
    wait_flag();
    chk("R1 wrap low", snap_lo, 8'hE0);
    chk("R1 wrap high", snap_hi, 0);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0; #2;
    chk("R5 ack clears", snap_fl, 0);

    // R4: reload mode
    wr(2'd2, 8'h10);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hFE);
    wr(2'd2, 8'h11);
    wait_flag();
    chk("R4 reload low", snap_lo, 8'h80);
    chk("R4 high kept", snap_hi, 8'h80);
    pulse_clr();

    // R2: gate
    wr(2'd2, 8'h0A);            // mode 16, gate enabled, stopped
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    gate_pin = 1'b0;
    wr(2'd2, 8'h0B);
    idle(30); #2;
    chk("R2 gate low blocks", snap_lo, 0);
    gate_pin = 1'b1;
    idle(30); #2;
    chk("R2 gate high counts 5 ticks (R6)", snap_lo, 5);
    gate_pin = 1'b0;

    // R6: external falling edges
    wr(2'd2, 8'h0C);            // mode 16, external, stopped
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0D);
    for (int k = 0; k < 4; k++) begin
      cnt_pin = 1'b1; idle(14);
      cnt_pin = 1'b0; idle(14);
    end
    idle(20); #2;
    chk("R6 four falling edges", snap_lo, 4);

    // R7: continuous writes beat increments
    wr(2'd2, 8'h08);
    wr(2'd1, 8'h07);
    wr(2'd2, 8'h09);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h55;
    idle(20);
    wr_en = 1'b0; #2;
    chk("R7 low written", snap_lo, 8'h55);
    chk("R7 high held", snap_hi, 8'h07);

    // R8: hold mode
    wr(2'd2, 8'h19);
    idle(40); #2;
    chk("R8 hold low", snap_lo, 8'h55);
    chk("R8 hold high", snap_hi, 8'h07);

    // R5: wrap with clear held high keeps the flag for one cycle
    wr(2'd2, 8'h08);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    @(negedge clk); flag_clr = 1'b1;
    wr(2'd2, 8'h09);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #2;
        if (ovf_flag) seen++;
      end
      chk("R5 set beats clear, one cycle", seen, 1);
    end
    flag_clr = 1'b0;

    // Random phase, reference compared every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 7) == 0);
      wr_sel = 2'($urandom_range(0, 2));
      wr_data = 8'($urandom_range(0, 255));
      if (wr_sel == 2'd2) wr_data[0] = 1'b1;
      if ($urandom_range(0, 9) == 0) cnt_pin = ~cnt_pin;
      if ($urandom_range(0, 5) == 0) gate_pin = ~gate_pin;
      flag_clr = ($urandom_range(0, 39) == 0);
      irq_ack  = ($urandom_range(0, 39) == 0);
    end
    @(negedge clk);
    wr_en = 1'b0; flag_clr = 1'b0; irq_ack = 1'b0;
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule